// File: doc/BRIEF.md
# Character Display Parallel Bus Engine

This block is the host-side engine for a character display module that hangs on an 8-line parallel bus with register-select, read/write and enable strobes. A client hands it one transfer at a time over a valid/ready request channel. The request carries the register select, the direction, a write byte and a flag that asks for busy polling. The engine drives the bus. It spaces the enable strobe so that the address setup, enable width, data setup, read delay, hold and full-cycle limits are met at the configured clock period. It then returns the outcome on a valid/ready response channel.

A plain `nibble_mode` input, sampled when a request is accepted, selects the narrow 4-line form. In that form each byte takes two enable cycles on the upper four data lines, high half first. When polling is requested, the engine follows the transfer with status reads of the instruction register and holds back the response until bit 7 of the status byte reads 0. Outbound data leaves on `bus_d_out` with an output-enable `bus_d_oe` for an external tri-state pad, and inbound data arrives on `bus_d_in`.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the response has been taken. A response is offered with `rsp_valid` and stays, unchanged, until a clock edge with `rsp_ready` high.

Top module: `chardisp_bus_engine`

## Requirements
- R1: `req_ready` is high only when no transfer is in flight. It drops on the edge that accepts a request and returns only after the response has been accepted.
- R2: `bus_rs` and `bus_rw` settle at least 40 ns (8 cycles at 5 ns) before `bus_en` rises. They do not change while `bus_en` is high, and they stay put at least 10 ns (2 cycles) after it falls.
- R3: `bus_en` is high for exactly max(230 ns, read delay + 1 cycle) rounded up to cycles, which is 46 cycles by default. Two successive rising edges are at least 500 ns (100 cycles) apart.
- R4: On a write cycle, `bus_d_oe` is high and `bus_d_out` holds one value from the start of address setup until after the hold time. The data is therefore valid at least 80 ns before `bus_en` falls.
- R5: On any cycle with `bus_rw`=1, `bus_d_oe` is low throughout. The read byte is captured on the clock edge at which `bus_en` falls, which is after the 160 ns read delay.
- R6: With `nibble_mode`=0, each byte moves in one enable cycle on all eight data lines.
- R7: With `nibble_mode`=1, each byte takes two enable cycles on data lines 7..4. Bits 7..4 of the byte go first and bits 3..0 go second. `bus_d_out[3:0]` is 0 in this mode.
- R8: With `req_poll`=1, after the transfer the engine issues status reads (`bus_rs`=0, `bus_rw`=1) until a status byte with bit 7 = 0 arrives. Only then does it offer a response.
- R9: `rsp_data` is the byte read for a read request and 8'h00 for a write. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold.
- R10: During and right after reset, `bus_en`=0, `bus_d_oe`=0, `rsp_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nibble_mode | input | 1 | 1 selects the 4-line form, sampled at request acceptance |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can take a request |
| req_rs | input | 1 | Register select: 0 instruction, 1 data |
| req_rw | input | 1 | Direction: 1 read from module, 0 write to module |
| req_wdata | input | 8 | Byte to write |
| req_poll | input | 1 | Poll busy flag before responding |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Client takes the response |
| rsp_data | output | 8 | Read byte, or 0 for a write |
| bus_rs | output | 1 | Bus register select |
| bus_rw | output | 1 | Bus direction |
| bus_en | output | 1 | Bus enable strobe |
| bus_d_out | output | 8 | Data toward the module |
| bus_d_oe | output | 1 | Drive enable for the data pads |
| bus_d_in | input | 8 | Data from the module |

## Verification
The bench models the module so that read data turns valid only 160 ns into the enable pulse, with a garbage pattern whose bit 7 is set before that. An engine that sampled early would return the wrong bytes, or would spin in polling on a false busy flag. Narrow-mode writes are reassembled from the two halves and compared in order, which catches swapped halves and single-cycle bytes. Poll runs with several busy replies check the exact number of status reads, so an engine that quit polling early or stopped one read late shows a count mismatch. A held-off response checks that data and valid do not move under back-pressure. Every enable pulse is timed for width, rise-to-rise spacing, address setup and hold.

// File: rtl/cdbe_pkg.sv
`timescale 1ns/1ps
package cdbe_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_HIGH, PH_HOLD, PH_GAP
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_XFER, ST_POLL, ST_RESP
  } xfer_st_e;

  function automatic int ns_to_cyc(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cdbe_strobe_timer.sv
`timescale 1ns/1ps
module cdbe_strobe_timer
  import cdbe_pkg::*;
#(
  parameter int SETUP_C = 8,
  parameter int HIGH_C  = 46,
  parameter int HOLD_C  = 2,
  parameter int GAP_C   = 44
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic en,
  output logic sample,
  output logic last
);
  localparam int MAXC = imax(imax(SETUP_C, HIGH_C), imax(HOLD_C, GAP_C));
  localparam int CW   = $clog2(MAXC + 1);

  phase_e        ph;
  logic [CW-1:0] cnt;
  logic          zero;

  assign zero   = (cnt == '0);
  assign en     = (ph == PH_HIGH);
  assign sample = (ph == PH_HIGH) && zero;

  // the cycle ends in the gap phase, or in hold when no gap is needed
  generate
    if (GAP_C > 0) begin : g_gap
      assign last = (ph == PH_GAP) && zero;
    end else begin : g_nogap
      assign last = (ph == PH_HOLD) && zero;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else if (start) begin
      ph  <= PH_SETUP;
      cnt <= CW'(SETUP_C - 1);
    end else if (!zero) begin
      cnt <= cnt - 1'b1;
    end else begin
      case (ph)
        PH_SETUP: begin ph <= PH_HIGH; cnt <= CW'(HIGH_C - 1); end
        PH_HIGH:  begin ph <= PH_HOLD; cnt <= CW'(HOLD_C - 1); end
        PH_HOLD: begin
          if (GAP_C > 0) begin
            ph  <= PH_GAP;
            cnt <= CW'(imax(GAP_C, 1) - 1);
          end else begin
            ph <= PH_IDLE;
          end
        end
        PH_GAP:  ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R3: a new strobe cycle may only begin once the previous one has ended
  a_r3_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (ph == PH_IDLE || last));
endmodule

// File: rtl/cdbe_xfer_ctrl.sv
`timescale 1ns/1ps
module cdbe_xfer_ctrl
  import cdbe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nibble_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_rs,
  input  logic              req_rw,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic              req_poll,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              tm_start,
  input  logic              tm_sample,
  input  logic              tm_last,
  output logic              bus_rs,
  output logic              bus_rw,
  output logic [BYTE_W-1:0] bus_d_out,
  output logic              bus_d_oe,
  input  logic [BYTE_W-1:0] bus_d_in
);
  xfer_st_e          st;
  logic              nib_q, half_q, rw_q, poll_q;
  logic [BYTE_W-1:0] wbyte_q, rdata_q, stat_q;
  logic              accept, x_done, p_done, more_nib, still_busy;

  assign req_ready  = (st == ST_IDLE);
  assign rsp_valid  = (st == ST_RESP);
  assign rsp_data   = rdata_q;
  assign accept     = req_valid && (st == ST_IDLE);
  assign x_done     = (st == ST_XFER) && tm_last;
  assign p_done     = (st == ST_POLL) && tm_last;
  assign more_nib   = nib_q && !half_q;
  assign still_busy = stat_q[BYTE_W-1];

  assign tm_start = accept
                 || ((x_done || p_done) && more_nib)
                 || (x_done && !more_nib && poll_q)
                 || (p_done && !more_nib && still_busy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      nib_q     <= 1'b0;
      half_q    <= 1'b0;
      rw_q      <= 1'b0;
      poll_q    <= 1'b0;
      wbyte_q   <= '0;
      bus_rs    <= 1'b0;
      bus_rw    <= 1'b0;
      bus_d_oe  <= 1'b0;
      bus_d_out <= '0;
    end else if (accept) begin
      st        <= ST_XFER;
      nib_q     <= nibble_mode;
      half_q    <= 1'b0;
      rw_q      <= req_rw;
      poll_q    <= req_poll;
      wbyte_q   <= req_wdata;
      bus_rs    <= req_rs;
      bus_rw    <= req_rw;
      bus_d_oe  <= !req_rw;
      bus_d_out <= nibble_mode ? {req_wdata[BYTE_W-1:NIB_W], NIB_W'(0)} : req_wdata;
    end else if ((x_done || p_done) && more_nib) begin
      half_q <= 1'b1;
      if (st == ST_XFER && !rw_q) bus_d_out <= {wbyte_q[NIB_W-1:0], NIB_W'(0)};
    end else if (x_done) begin
      bus_d_oe <= 1'b0;
      if (poll_q) begin
        st     <= ST_POLL;
        half_q <= 1'b0;
        bus_rs <= 1'b0;
        bus_rw <= 1'b1;
      end else begin
        st <= ST_RESP;
      end
    end else if (p_done) begin
      if (still_busy) half_q <= 1'b0;
      else            st     <= ST_RESP;
    end else if (st == ST_RESP && rsp_ready) begin
      st <= ST_IDLE;
    end
  end

  // capture path: the byte of the transfer, or the status of a poll read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      stat_q  <= '0;
    end else if (accept) begin
      rdata_q <= '0;
    end else if (tm_sample && bus_rw) begin
      if (st == ST_XFER) begin
        if (!nib_q)      rdata_q                <= bus_d_in;
        else if (half_q) rdata_q[NIB_W-1:0]     <= bus_d_in[BYTE_W-1:NIB_W];
        else             rdata_q[BYTE_W-1:NIB_W] <= bus_d_in[BYTE_W-1:NIB_W];
      end else begin
        if (!nib_q)      stat_q                 <= bus_d_in;
        else if (half_q) stat_q[NIB_W-1:0]      <= bus_d_in[BYTE_W-1:NIB_W];
        else             stat_q[BYTE_W-1:NIB_W]  <= bus_d_in[BYTE_W-1:NIB_W];
      end
    end
  end

  // R9: an offered response holds still under back-pressure
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  // R1: request and response channels are never open together
  a_r1_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid);
  // R8: a polled transfer only answers once the busy flag has cleared
  a_r8_poll_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && poll_q |-> !stat_q[BYTE_W-1]);
endmodule

// File: rtl/chardisp_bus_engine.sv
`timescale 1ns/1ps
module chardisp_bus_engine
  import cdbe_pkg::*;
#(
  parameter int CLK_NS   = 5,
  parameter int T_AS_NS  = 40,
  parameter int T_PW_NS  = 230,
  parameter int T_AH_NS  = 10,
  parameter int T_CYC_NS = 500,
  parameter int T_DSW_NS = 80,
  parameter int T_DDR_NS = 160
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nibble_mode,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_rs,
  input  logic       req_rw,
  input  logic [7:0] req_wdata,
  input  logic       req_poll,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic       bus_rs,
  output logic       bus_rw,
  output logic       bus_en,
  output logic [7:0] bus_d_out,
  output logic       bus_d_oe,
  input  logic [7:0] bus_d_in
);
  localparam int AS_C  = imax(ns_to_cyc(T_AS_NS, CLK_NS), 1);
  localparam int PW_C  = imax(imax(ns_to_cyc(T_PW_NS, CLK_NS), ns_to_cyc(T_DDR_NS, CLK_NS) + 1),
                              ns_to_cyc(T_DSW_NS, CLK_NS));
  localparam int AH_C  = imax(ns_to_cyc(T_AH_NS, CLK_NS), 1);
  localparam int CYC_C = ns_to_cyc(T_CYC_NS, CLK_NS);
  localparam int GAP_C = (CYC_C > AS_C + PW_C + AH_C) ? (CYC_C - AS_C - PW_C - AH_C) : 0;

  logic tm_start, tm_sample, tm_last;

  cdbe_strobe_timer #(
    .SETUP_C(AS_C), .HIGH_C(PW_C), .HOLD_C(AH_C), .GAP_C(GAP_C)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tm_start),
    .en(bus_en), .sample(tm_sample), .last(tm_last)
  );

  cdbe_xfer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .nibble_mode(nibble_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_rs(req_rs), .req_rw(req_rw),
    .req_wdata(req_wdata), .req_poll(req_poll),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .tm_start(tm_start), .tm_sample(tm_sample), .tm_last(tm_last),
    .bus_rs(bus_rs), .bus_rw(bus_rw), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
    .bus_d_in(bus_d_in)
  );

  // observation counters for the bus timing properties
  localparam int HW = $clog2(PW_C + 2);
  localparam int AW = $clog2(AS_C + 2);
  logic [HW-1:0] hi_cnt;
  logic [AW-1:0] addr_age;
  logic          rs_q, rw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      addr_age <= '0;
      rs_q     <= 1'b0;
      rw_q     <= 1'b0;
    end else begin
      hi_cnt <= bus_en ? hi_cnt + 1'b1 : '0;
      rs_q   <= bus_rs;
      rw_q   <= bus_rw;
      if ({bus_rs, bus_rw} != {rs_q, rw_q}) addr_age <= '0;
      else if (int'(addr_age) < AS_C)       addr_age <= addr_age + 1'b1;
    end
  end

  // R3: enable pulse lasts exactly the derived pulse length
  a_r3_en_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_en) |-> (int'(hi_cnt) == PW_C));
  // R2: select and direction settled for the setup time before the strobe
  a_r2_addr_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_en) |-> (int'(addr_age) >= AS_C - 1));
  // R2: select and direction frozen while the strobe is high
  a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && $past(bus_en) |-> $stable(bus_rs) && $stable(bus_rw));
  // R5: the engine never drives the data lines during a read strobe
  a_r5_read_float: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && bus_rw |-> !bus_d_oe);
endmodule

// File: tb/chardisp_bus_engine_test.sv
`timescale 1ns/1ps
module chardisp_bus_engine_test;
  localparam int P   = 5;
  localparam int AS  = (40 + P - 1) / P;
  localparam int PW  = (230 + P - 1) / P;
  localparam int AH  = (10 + P - 1) / P;
  localparam int CYC = (500 + P - 1) / P;
  localparam int DSW = (80 + P - 1) / P;
  localparam int DDR = (160 + P - 1) / P;

  logic clk = 1'b0, rst_n = 1'b0, nibble_mode = 1'b0;
  logic req_valid = 1'b0, req_rs = 1'b0, req_rw = 1'b0, req_poll = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_wdata = 8'h00;
  logic req_ready, rsp_valid, bus_rs, bus_rw, bus_en, bus_d_oe;
  logic [7:0] rsp_data, bus_d_out, bus_d_in;

  always #2.5 clk = ~clk;

  chardisp_bus_engine uut (
    .clk(clk), .rst_n(rst_n), .nibble_mode(nibble_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_rs(req_rs), .req_rw(req_rw),
    .req_wdata(req_wdata), .req_poll(req_poll),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .bus_rs(bus_rs), .bus_rw(bus_rw), .bus_en(bus_en), .bus_d_out(bus_d_out),
    .bus_d_oe(bus_d_oe), .bus_d_in(bus_d_in)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, rsp_cnt = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // display module model
  bit m_nib = 1'b0, nib_hi = 1'b1, float_bad = 1'b0, seen_rise = 1'b0, seen_fall = 1'b0;
  int busy_left = 0, stat_reads = 0, hi_cnt = 0;
  int since_addr = 0, since_fall = 0, since_rise = 0, since_data = 0;
  logic [7:0] dreg = 8'h00, wbuf = 8'h00, p_dout = 8'h00;
  logic [6:0] ac = 7'h00;
  logic p_en = 1'b0, p_rs = 1'b0, p_rw = 1'b0, p_oe = 1'b0;
  logic [7:0] cur;
  logic [8:0] wq[$];
  logic [7:0] rq[$];

  assign cur = bus_rs ? dreg : {(busy_left != 0), ac};
  assign bus_d_in = (bus_en && hi_cnt >= DDR)
                  ? (m_nib ? (nib_hi ? {cur[7:4], 4'hF} : {cur[3:0], 4'hF}) : cur)
                  : 8'hA5;

  always @(negedge clk) begin
    if (rst_n) begin
      logic rise, fall, byte_done;
      rise = bus_en && !p_en;
      fall = !bus_en && p_en;
      if ({bus_rs, bus_rw} != {p_rs, p_rw}) begin
        chk(!bus_en && !p_en, "R2 select moved around strobe", {bus_rs, bus_rw}, {p_rs, p_rw});
        if (seen_fall) chk(since_fall >= AH, "R2 hold after strobe", since_fall, AH);
        since_addr = 0;
      end
      if (bus_d_out != p_dout || bus_d_oe != p_oe) since_data = 0;
      if (bus_en && bus_rw && bus_d_oe) float_bad = 1'b1;
      if (rise) begin
        chk(since_addr >= AS, "R2 address setup", since_addr, AS);
        if (seen_rise) chk(since_rise >= CYC, "R3 rise spacing", since_rise, CYC);
        since_rise = 0;
        seen_rise = 1'b1;
      end
      if (fall) begin
        chk(hi_cnt == PW, "R3 enable width", hi_cnt, PW);
        byte_done = !m_nib || !nib_hi;
        if (!bus_rw) begin
          chk(bus_d_oe, "R4 write drive", bus_d_oe, 1);
          chk(since_data >= PW + AS && since_data >= DSW, "R4 write data setup", since_data, PW + AS);
          if (m_nib) begin
            chk(bus_d_out[3:0] == 4'h0, "R7 low lines quiet", bus_d_out, {bus_d_out[7:4], 4'h0});
            if (nib_hi) wbuf[7:4] = bus_d_out[7:4];
            else        wbuf[3:0] = bus_d_out[7:4];
          end else begin
            wbuf = bus_d_out;
          end
          if (byte_done) begin
            if (wq.size() == 0) chk(1'b0, "R6/R7 unexpected write", {bus_rs, wbuf}, 0);
            else begin
              logic [8:0] e;
              e = wq.pop_front();
              chk({bus_rs, wbuf} == e, "R6/R7 written byte", {bus_rs, wbuf}, e);
            end
          end
        end else begin
          chk(!float_bad, "R5 data lines floated on read", float_bad, 0);
          if (byte_done && !bus_rs) begin
            stat_reads++;
            if (busy_left > 0) busy_left--;
          end
        end
        float_bad = 1'b0;
        if (m_nib) nib_hi = !nib_hi;
        since_fall = 0;
        seen_fall = 1'b1;
      end
      hi_cnt = bus_en ? hi_cnt + 1 : 0;
      since_addr++; since_fall++; since_rise++; since_data++;
      p_en = bus_en; p_rs = bus_rs; p_rw = bus_rw; p_dout = bus_d_out; p_oe = bus_d_oe;
      // scoreboard monitor for responses
      if (rsp_valid && rsp_ready) begin
        if (rq.size() == 0) chk(1'b0, "R9 unexpected response", rsp_data, 0);
        else begin
          logic [7:0] e;
          e = rq.pop_front();
          chk(rsp_data == e, "R9 response byte", rsp_data, e);
        end
        rsp_cnt++;
      end
    end
  end

  task automatic xfer(input bit rs, input bit rw, input logic [7:0] w, input bit poll,
                      input logic [7:0] exp, input int exp_stat, input string tag);
    int target, s0;
    target = rsp_cnt + 1;
    s0 = stat_reads;
    rq.push_back(exp);
    if (!rw) wq.push_back({rs, w});
    @(posedge clk); #1;
    req_rs = rs; req_rw = rw; req_wdata = w; req_poll = poll; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(!req_ready, "R1 busy after accept", req_ready, 0);
    while (rsp_cnt < target && !finished) @(negedge clk);
    @(negedge clk);
    chk(req_ready, "R1 ready after response", req_ready, 1);
    chk(stat_reads - s0 == exp_stat, {"R8 status read count ", tag}, stat_reads - s0, exp_stat);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (10) @(negedge clk);
    chk(!bus_en && !bus_d_oe && !rsp_valid && req_ready, "R10 reset state",
        {bus_en, bus_d_oe, rsp_valid, req_ready}, 4'b0001);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_en && !bus_d_oe && !rsp_valid && req_ready, "R10 after reset",
        {bus_en, bus_d_oe, rsp_valid, req_ready}, 4'b0001);

    // 8-bit mode (R6)
    m_nib = 1'b0; nibble_mode = 1'b0;
    xfer(1'b0, 1'b0, 8'h38, 1'b0, 8'h00, 0, "R6 instr write");
    xfer(1'b1, 1'b0, 8'hA7, 1'b0, 8'h00, 0, "R6 data write");
    dreg = 8'h5C;
    xfer(1'b1, 1'b1, 8'h00, 1'b0, 8'h5C, 0, "R5 data read");
    ac = 7'h15; busy_left = 0;
    xfer(1'b0, 1'b1, 8'h00, 1'b0, 8'h15, 1, "R5 status read");
    busy_left = 3;
    xfer(1'b0, 1'b0, 8'h01, 1'b1, 8'h00, 4, "R8 polled write");

    // 4-bit mode (R7)
    m_nib = 1'b1; nibble_mode = 1'b1; nib_hi = 1'b1;
    xfer(1'b1, 1'b0, 8'h9E, 1'b0, 8'h00, 0, "R7 narrow write");
    dreg = 8'h3B;
    xfer(1'b1, 1'b1, 8'h00, 1'b0, 8'h3B, 0, "R7 narrow read");
    busy_left = 2;
    xfer(1'b0, 1'b0, 8'h28, 1'b1, 8'h00, 3, "R8 narrow polled write");
    ac = 7'h4E; busy_left = 1;
    xfer(1'b0, 1'b1, 8'h00, 1'b1, 8'hCE, 2, "R8 narrow polled status");

    // back-pressure on the response (R9)
    m_nib = 1'b0; nibble_mode = 1'b0; dreg = 8'hE1;
    @(posedge clk); #1 rsp_ready = 1'b0;
    rq.push_back(8'hE1);
    req_rs = 1'b1; req_rw = 1'b1; req_poll = 1'b0; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1 req_valid = 1'b0;
    while (!rsp_valid && !finished) @(negedge clk);
    begin
      logic [7:0] held;
      bit steady;
      held = rsp_data;
      steady = 1'b1;
      repeat (20) begin
        @(negedge clk);
        if (!rsp_valid || rsp_data != held) steady = 1'b0;
      end
      chk(steady, "R9 response held under back-pressure", rsp_data, held);
      chk(!req_ready, "R1 no request while response pending", req_ready, 0);
    end
    @(posedge clk); #1 rsp_ready = 1'b1;
    while (rsp_cnt < 10 && !finished) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(rq.size() == 0 && wq.size() == 0, "R9 scoreboard drained", rq.size() + wq.size(), 0);
    summary();
  end
endmodule